// File: doc/BRIEF.md
# Programmable 16-bit Timer Channel

This block is one channel of a general-purpose timer. A 16-bit counter advances on ticks from a power-of-two clock divider. It either runs freely across the full 16-bit range or wraps at a programmed interval, and it can count up or down. On every tick it can compare the new count with three programmable match values. Wraps and matches raise sticky status flags. A per-flag enable mask reduces them to one level interrupt line.

Software-side decoding sits outside the block. Each configuration register has its own write strobe and data bus. The status register has a read strobe that empties it and a write-one-to-clear path. The block carries no streaming data, so every pin is a plain control or status signal, and nothing on it uses valid/ready handshaking. Every write takes effect at the clock edge where its strobe is high. The count, status and interrupt outputs come straight from registers, or from registers through gates.

Top module: `tmr16_channel`

## Requirements
- R1: With clock-control bit 0 low, the counter ticks on every enabled cycle. With bit 0 high and bits [4:1] holding N, it ticks once every 2^(N+1) cycles. Writing clock control restarts the divider.
- R2: After reset, counter control reads 0x21, so counting is stopped (bit 0 = stop), and the count, status and interrupt are 0. Bit 4 of counter control always reads back as 0.
- R3: Writing counter control with bit 4 set restarts the count. The count becomes 0 when the written bit 2 (down) is low, and the active limit when it is high. The divider restarts and that cycle produces no tick or flag.
- R4: In free-running mode (bit 1 low), counting up from 0xFFFF wraps to 0 and sets status bit 4.
- R5: In interval mode (bit 1 high), the limit is the interval register, and the counter wraps to 0 after reaching it. The wrap sets status bit 0. An interval of 0 behaves as 1.
- R6: In down mode (bit 2 high), the counter decrements. A tick at 0 reloads the limit and sets the same wrap flag as in R4/R5.
- R7: With bit 3 high, a tick whose new count equals match register k (k = 0..2) sets status bit k+1. With bit 3 low, no match flag is set.
- R8: The interrupt output is high exactly when status AND the 6-bit enable mask is nonzero.
- R9: A status read strobe clears all status bits. Writing 1s to status clears those bits. A flag set in the same cycle as either clear survives.
- R10: The interval and match registers keep only the low 16 bits of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_cfg_we | input | 1 | Clock-control write strobe |
| clk_cfg_wdata | input | 6 | Clock control: bit 0 divider enable, [4:1] divider select |
| cnt_cfg_we | input | 1 | Counter-control write strobe |
| cnt_cfg_wdata | input | 6 | Bit 0 stop, 1 interval, 2 down, 3 match enable, 4 restart |
| intv_we | input | 1 | Interval write strobe |
| intv_wdata | input | 32 | Interval write data (low 16 bits kept) |
| match_we | input | 3 | Per-match-register write strobes |
| match_wdata | input | 32 | Match write data (low 16 bits kept) |
| irq_en_we | input | 1 | Enable-mask write strobe |
| irq_en_wdata | input | 6 | Enable mask |
| stat_clr_we | input | 1 | Status write-one-to-clear strobe |
| stat_clr_wdata | input | 6 | Bits of status to clear |
| stat_rd | input | 1 | Status read strobe (clears all) |
| count_o | output | 16 | Current count |
| cnt_cfg_o | output | 6 | Counter-control readback |
| status_o | output | 6 | Status: 0 wrap-interval, 1..3 match, 4 overflow, 5 event |
| irq_o | output | 1 | Level interrupt |

## Verification
Two functions can fall in the same cycle: a flag being raised by a wrap or match tick, and status being emptied by the read strobe or a write-one-to-clear. The bench holds the read strobe high across a whole interval period while the counter runs, so at least one read lands on the wrap edge and on a match edge. A behavioural model applies the rule that the new flag survives, and the status, count and interrupt are compared against it on every cycle.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  // counter-control bit positions
  localparam int CTL_STOP    = 0;
  localparam int CTL_IMODE   = 1;
  localparam int CTL_DOWN    = 2;
  localparam int CTL_MEN     = 3;
  localparam int CTL_RESTART = 4;
  localparam logic [5:0] CTL_RESET_VAL = 6'h21;

  // status bit positions
  localparam int ST_INTV  = 0;
  localparam int ST_MATCH = 1;
  localparam int ST_OVF   = 4;
  localparam int ST_EVT   = 5;

  // clock-control bit positions
  localparam int CK_PS_EN  = 0;
  localparam int CK_SEL_LO = 1;
endpackage

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
  parameter int PS_SEL_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic                ps_en_i,
  input  logic [PS_SEL_W-1:0] ps_sel_i,
  input  logic                restart_i,
  output logic                tick_o
);
  localparam int DIV_W = 2 ** PS_SEL_W;
  localparam int SH_W  = PS_SEL_W + 1;

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] term;
  logic [SH_W-1:0]  shamt;

  always_comb begin
    shamt = {1'b0, ps_sel_i} + 1'b1;
    term  = ~({DIV_W{1'b1}} << shamt);
  end

  assign tick_o = run_i & (~ps_en_i | (pre_q == term));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (run_i && ps_en_i) pre_q <= (pre_q == term) ? '0 : pre_q + 1'b1;
  end

  // R1: a divided tick stream never has two ticks back to back
  divided_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && ps_en_i && !restart_i) |=> !tick_o);
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter
  import tmr16_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_MATCH = 3,
  parameter int CFG_W     = 6,
  parameter int STAT_W    = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_i,
  input  logic [CFG_W-1:0]           cfg_i,
  input  logic                       cfg_we_i,
  input  logic [CFG_W-1:0]           cfg_wdata_i,
  input  logic [CNT_W-1:0]           intv_i,
  input  logic [NUM_MATCH*CNT_W-1:0] match_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic [STAT_W-1:0]          set_o
);
  logic [CNT_W-1:0]     cnt_q, cnt_nx, lim, rst_lim, intv_eff;
  logic                 restart, wrap, adv;
  logic [NUM_MATCH-1:0] hit;

  assign intv_eff = (intv_i == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : intv_i;
  assign lim      = cfg_i[CTL_IMODE] ? intv_eff : {CNT_W{1'b1}};
  assign rst_lim  = cfg_wdata_i[CTL_IMODE] ? intv_eff : {CNT_W{1'b1}};
  assign restart  = cfg_we_i & cfg_wdata_i[CTL_RESTART];
  assign adv      = tick_i & ~restart;

  always_comb begin
    if (cfg_i[CTL_DOWN]) begin
      wrap   = (cnt_q == '0);
      cnt_nx = wrap ? lim : cnt_q - 1'b1;
    end else begin
      wrap   = (cnt_q >= lim);
      cnt_nx = wrap ? '0 : cnt_q + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_cmp
    assign hit[k] = adv & cfg_i[CTL_MEN] & (cnt_nx == match_i[k*CNT_W +: CNT_W]);
  end

  always_comb begin
    set_o = '0;
    if (cfg_i[CTL_IMODE]) set_o[ST_INTV] = adv & wrap;
    else                  set_o[ST_OVF]  = adv & wrap;
    set_o[ST_MATCH +: NUM_MATCH] = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (restart) cnt_q <= cfg_wdata_i[CTL_DOWN] ? rst_lim : '0;
    else if (tick_i) cnt_q <= cnt_nx;
  end

  assign cnt_o = cnt_q;

  // R4 / R5: an upward wrap lands on zero
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cfg_we_i && !cfg_i[CTL_DOWN] && cnt_q == lim) |=> (cnt_q == '0));
  // R6: a downward tick at zero reloads the limit
  down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cfg_we_i && cfg_i[CTL_DOWN] && cnt_q == '0) |=> (cnt_q == $past(lim)));
  // R3: an upward restart always leaves zero
  restart_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !cfg_wdata_i[CTL_DOWN]) |=> (cnt_q == '0));
  // R7: match flags only with compare enabled
  match_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i[CTL_MEN] |-> (set_o[ST_MATCH +: NUM_MATCH] == '0));
endmodule

// File: rtl/tmr16_irq.sv
module tmr16_irq #(
  parameter int STAT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_mask_i,
  input  logic              rd_clr_i,
  input  logic              en_we_i,
  input  logic [STAT_W-1:0] en_wdata_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] stat_q, en_q, keep;

  always_comb begin
    keep = stat_q;
    if (clr_we_i) keep = keep & ~clr_mask_i;
    if (rd_clr_i) keep = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= keep | set_i;
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign status_o = stat_q;
  assign irq_o    = |(stat_q & en_q);

  // R9: a freshly raised flag is always visible next cycle
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i)));
  // R9: read with nothing raised empties status
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && set_i == '0) |=> (stat_q == '0));
  // R8: no status means no interrupt
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |-> !irq_o);
endmodule

// File: rtl/tmr16_channel.sv
module tmr16_channel
  import tmr16_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BUS_W     = 32,
  parameter int NUM_MATCH = 3,
  parameter int CFG_W     = 6,
  parameter int STAT_W    = 6,
  parameter int PS_SEL_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_cfg_we,
  input  logic [CFG_W-1:0]     clk_cfg_wdata,
  input  logic                 cnt_cfg_we,
  input  logic [CFG_W-1:0]     cnt_cfg_wdata,
  input  logic                 intv_we,
  input  logic [BUS_W-1:0]     intv_wdata,
  input  logic [NUM_MATCH-1:0] match_we,
  input  logic [BUS_W-1:0]     match_wdata,
  input  logic                 irq_en_we,
  input  logic [STAT_W-1:0]    irq_en_wdata,
  input  logic                 stat_clr_we,
  input  logic [STAT_W-1:0]    stat_clr_wdata,
  input  logic                 stat_rd,
  output logic [CNT_W-1:0]     count_o,
  output logic [CFG_W-1:0]     cnt_cfg_o,
  output logic [STAT_W-1:0]    status_o,
  output logic                 irq_o
);
  logic [CFG_W-1:0]           clk_cfg_q, cnt_cfg_q;
  logic [CNT_W-1:0]           intv_q;
  logic [NUM_MATCH*CNT_W-1:0] match_q;
  logic [STAT_W-1:0]          set_flags;
  logic                       tick, ps_restart;
  logic                       unused_hi;

  assign unused_hi = ^{intv_wdata[BUS_W-1:CNT_W], match_wdata[BUS_W-1:CNT_W],
                       clk_cfg_q[CFG_W-1:CK_SEL_LO+PS_SEL_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_cfg_q <= '0;
      cnt_cfg_q <= CTL_RESET_VAL;
      intv_q    <= '0;
    end else begin
      if (clk_cfg_we) clk_cfg_q <= clk_cfg_wdata;
      if (cnt_cfg_we) begin
        cnt_cfg_q              <= cnt_cfg_wdata;
        cnt_cfg_q[CTL_RESTART] <= 1'b0;
      end
      if (intv_we) intv_q <= intv_wdata[CNT_W-1:0];
    end
  end

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_match
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q[k*CNT_W +: CNT_W] <= '0;
      else if (match_we[k]) match_q[k*CNT_W +: CNT_W] <= match_wdata[CNT_W-1:0];
    end
  end

  assign ps_restart = clk_cfg_we | (cnt_cfg_we & cnt_cfg_wdata[CTL_RESTART]);

  tmr16_prescaler #(.PS_SEL_W(PS_SEL_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (~cnt_cfg_q[CTL_STOP]),
    .ps_en_i   (clk_cfg_q[CK_PS_EN]),
    .ps_sel_i  (clk_cfg_q[CK_SEL_LO +: PS_SEL_W]),
    .restart_i (ps_restart),
    .tick_o    (tick)
  );

  tmr16_counter #(
    .CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .CFG_W(CFG_W), .STAT_W(STAT_W)
  ) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .cfg_i       (cnt_cfg_q),
    .cfg_we_i    (cnt_cfg_we),
    .cfg_wdata_i (cnt_cfg_wdata),
    .intv_i      (intv_q),
    .match_i     (match_q),
    .cnt_o       (count_o),
    .set_o       (set_flags)
  );

  tmr16_irq #(.STAT_W(STAT_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_flags),
    .clr_we_i   (stat_clr_we),
    .clr_mask_i (stat_clr_wdata),
    .rd_clr_i   (stat_rd),
    .en_we_i    (irq_en_we),
    .en_wdata_i (irq_en_wdata),
    .status_o   (status_o),
    .irq_o      (irq_o)
  );

  assign cnt_cfg_o = cnt_cfg_q;

  // R2: restart request never reads back
  restart_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_cfg_we |=> !cnt_cfg_o[CTL_RESTART]);
  // R2: a stopped counter holds its value unless restarted
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_cfg_q[CTL_STOP] && !cnt_cfg_we) |=> $stable(count_o));
  // R8: raised status under enable gives interrupt one cycle later
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags[ST_INTV] && !irq_en_we && u_irq.en_q[ST_INTV]) |=> irq_o);
endmodule

// File: tb/test_tmr16_channel.sv
module test_tmr16_channel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        clk_cfg_we = 0, cnt_cfg_we = 0, intv_we = 0, irq_en_we = 0;
  logic        stat_clr_we = 0, stat_rd = 0;
  logic [5:0]  clk_cfg_wdata = 0, cnt_cfg_wdata = 0, irq_en_wdata = 0, stat_clr_wdata = 0;
  logic [31:0] intv_wdata = 0, match_wdata = 0;
  logic [2:0]  match_we = 0;
  logic [15:0] count_o;
  logic [5:0]  cnt_cfg_o, status_o;
  logic        irq_o;

  tmr16_channel i_tmr16_channel (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [5:0] m_clk, m_ctl, m_en, m_stat;
  int m_intv, m_cnt, m_pre;
  int m_match[3];

  function automatic int limit_of(input bit imode, input int iv);
    if (!imode) return 65535;
    return (iv == 0) ? 1 : iv;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clk = 0; m_ctl = 6'h21; m_en = 0; m_stat = 0;
      m_intv = 0; m_cnt = 0; m_pre = 0;
      foreach (m_match[k]) m_match[k] = 0;
    end else begin
      bit run, tk, rq;
      int term, lim, nx;
      logic [5:0] setv;
      run  = !m_ctl[0];
      term = (1 << (m_clk[4:1] + 1)) - 1;
      tk   = run && (!m_clk[0] || m_pre == term);
      rq   = cnt_cfg_we && cnt_cfg_wdata[4];
      if (clk_cfg_we || rq) m_pre = 0;
      else if (run && m_clk[0]) m_pre = (m_pre == term) ? 0 : m_pre + 1;
      lim  = limit_of(m_ctl[1], m_intv);
      setv = 0;
      if (rq) begin
        m_cnt = cnt_cfg_wdata[2] ? limit_of(cnt_cfg_wdata[1], m_intv) : 0;
      end else if (tk) begin
        bit w;
        if (!m_ctl[2]) begin w = (m_cnt >= lim); nx = w ? 0 : m_cnt + 1; end
        else           begin w = (m_cnt == 0);   nx = w ? lim : m_cnt - 1; end
        if (w) setv[m_ctl[1] ? 0 : 4] = 1'b1;
        if (m_ctl[3]) foreach (m_match[k]) if (nx == m_match[k]) setv[k+1] = 1'b1;
        m_cnt = nx;
      end
      if (stat_clr_we) m_stat = m_stat & ~stat_clr_wdata;
      if (stat_rd) m_stat = 0;
      m_stat = m_stat | setv;
      if (clk_cfg_we) m_clk = clk_cfg_wdata;
      if (cnt_cfg_we) m_ctl = cnt_cfg_wdata & 6'h2F;
      if (intv_we) m_intv = int'(intv_wdata[15:0]);
      for (int k = 0; k < 3; k++) if (match_we[k]) m_match[k] = int'(match_wdata[15:0]);
      if (irq_en_we) m_en = irq_en_wdata;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 R4 R5 R6 count", {16'h0, count_o}, m_cnt);
      chk("R7 R9 status", {26'h0, status_o}, {26'h0, m_stat});
      chk("R8 irq", {31'h0, irq_o}, {31'h0, |(m_stat & m_en)});
      chk("R2 ctl readback", {26'h0, cnt_cfg_o}, {26'h0, m_ctl});
    end
  end

  task automatic w_clk(input logic [5:0] v);
    clk_cfg_we = 1; clk_cfg_wdata = v; @(negedge clk); clk_cfg_we = 0;
  endtask
  task automatic w_ctl(input logic [5:0] v);
    cnt_cfg_we = 1; cnt_cfg_wdata = v; @(negedge clk); cnt_cfg_we = 0;
  endtask
  task automatic w_intv(input logic [31:0] v);
    intv_we = 1; intv_wdata = v; @(negedge clk); intv_we = 0;
  endtask
  task automatic w_match(input int k, input logic [31:0] v);
    match_we[k] = 1'b1; match_wdata = v; @(negedge clk); match_we = 0;
  endtask
  task automatic w_en(input logic [5:0] v);
    irq_en_we = 1; irq_en_wdata = v; @(negedge clk); irq_en_we = 0;
  endtask
  task automatic w_clr(input logic [5:0] v);
    stat_clr_we = 1; stat_clr_wdata = v; @(negedge clk); stat_clr_we = 0;
  endtask
  task automatic rd_status();
    stat_rd = 1; @(negedge clk); stat_rd = 0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk("R2 reset ctl", {26'h0, cnt_cfg_o}, 32'h21);
    chk("R2 reset count", {16'h0, count_o}, 0);
    chk("R2 reset status", {26'h0, status_o}, 0);
    chk("R2 reset irq", {31'h0, irq_o}, 0);
    repeat (4) @(negedge clk);
    chk("R2 stopped holds", {16'h0, count_o}, 0);

    // R3 restart, free-running up, undivided ticks (R1)
    w_ctl(6'h10);
    chk("R3 restart to zero", {16'h0, count_o}, 0);
    chk("R2 restart bit reads 0", {26'h0, cnt_cfg_o}, 32'h00);
    repeat (10) @(negedge clk);
    chk("R1 undivided rate", {16'h0, count_o}, 10);

    // R1 divide by 4
    w_clk(6'h03);
    w_ctl(6'h10);
    repeat (16) @(negedge clk);
    chk("R1 divide by four", {16'h0, count_o}, 4);
    w_clk(6'h00);

    // R5 R7 R10 interval with matches
    w_intv(32'hABCD_0005);
    w_match(0, 32'h1234_0002);
    w_match(1, 32'h0000_0005);
    w_match(2, 32'h0000_0007);
    w_en(6'h3F);
    w_clr(6'h3F);
    w_ctl(6'h1A);
    repeat (10) @(negedge clk);
    w_ctl(6'h0B);
    chk("R5 R7 R10 flags", {26'h0, status_o}, 32'h07);
    chk("R8 irq on", {31'h0, irq_o}, 1);

    // R9 per-bit clear, R8 mask
    w_clr(6'h02);
    chk("R9 write-one-clear", {26'h0, status_o}, 32'h05);
    w_en(6'h02);
    chk("R8 masked irq", {31'h0, irq_o}, 0);
    rd_status();
    chk("R9 read clears", {26'h0, status_o}, 0);
    w_en(6'h3F);

    // R9 collision: hold read strobe across a full period
    w_ctl(6'h1A);
    stat_rd = 1;
    repeat (12) @(negedge clk);
    stat_rd = 0;
    w_ctl(6'h0B);

    // R5 interval zero acts as one
    w_intv(0);
    w_ctl(6'h12);
    chk("R5 zero interval a", {16'h0, count_o}, 0);
    @(negedge clk);
    chk("R5 zero interval b", {16'h0, count_o}, 1);
    @(negedge clk);
    chk("R5 zero interval c", {16'h0, count_o}, 0);

    // R6 down interval
    w_intv(5);
    w_ctl(6'h16);
    chk("R6 down restart loads limit", {16'h0, count_o}, 5);
    @(negedge clk);
    chk("R6 decrement", {16'h0, count_o}, 4);
    w_clr(6'h3F);
    repeat (4) @(negedge clk);
    chk("R6 down wraps to limit", {16'h0, count_o}, 5);
    chk("R6 wrap flag", {31'h0, status_o[0]}, 1);

    // R4 free-run overflow
    w_ctl(6'h10);
    w_clr(6'h3F);
    repeat (65534) @(negedge clk);
    chk("R4 top value", {16'h0, count_o}, 32'hFFFF);
    @(negedge clk);
    chk("R4 wraps to zero", {16'h0, count_o}, 0);
    chk("R4 overflow flag", {26'h0, status_o}, 32'h10);

    // R3 down free-run restart
    w_ctl(6'h14);
    chk("R3 down restart", {16'h0, count_o}, 32'hFFFF);
    @(negedge clk);
    chk("R6 free down", {16'h0, count_o}, 32'hFFFE);

    // R7 compare disabled
    w_ctl(6'h12);
    w_clr(6'h3F);
    repeat (12) @(negedge clk);
    chk("R7 no match flags when disabled", {26'h0, status_o}, 32'h01);

    finish_up();
  end
endmodule